// File: doc/BRIEF.md
# Reply Cell Inserter

This block sits on the return path of a cell switch. It passes a 4-bit cell stream from the switching memory to the external controller. When the command interpreter asks for a reply, the block builds a 53-byte reply cell and splices it into the outgoing stream. It does this only at a cell boundary, in a clock where the forwarded stream is idle or is just finishing a cell.

While the reply goes out, the block drops its upstream run (read clock enable) output. The upstream source then holds its current frame marker and nibble unchanged, and the block's forwarding position counter freezes with it. Forwarding picks up again at the same point once the last nibble of the reply has been sent.

The interpreter hands over the reply fields with a one-clock request strobe:
- the command byte to echo;
- the sub-command;
- the cell number;
- the data count;
- up to 13 data bytes.

The block also takes in the current switch address. Replies to a null request and to a revision request are shaped inside the block. After every reset, one reset-notification reply is sent without any request. The HEC byte is always sent as zero.

Top module: `reply_cell_inserter`

## Requirements
- R1: With no reply being inserted, `dn_frm`/`dn_nib` equal `up_frm`/`up_nib` of the previous clock, and `up_run` is 1.
- R2: A cell on either stream is a frame-marker clock followed by 106 nibbles, starting in the next clock. Each byte is sent high nibble first. The marker of an inserted cell is high for one clock only.
- R3: An insertion starts only after a gap clock. A gap clock has `up_run`=1 and `up_frm`=0, and the forwarded stream is either idle or carrying nibble 105 of a cell. A forwarded cell is never split. In particular, a cell that follows another back-to-back is forwarded before any reply.
- R4: `up_run` is 0 for exactly the 107 clocks of an insertion. During that time the held upstream frame marker and nibble are not consumed, and forwarding resumes with them in the clock after nibble 105.
- R5: Reply header nibbles 0–9 are 0, except nibble 5, which carries the switch address [7:4], and nibble 6, which carries address [3:0]. The address is the value of `sw_addr` sampled in the gap clock that starts the insertion.
- R6: Reply payload byte 0 is the command, byte 1 the sub-command, byte 2 the cell number and byte 3 the data count. Bytes 4–16 are data bytes 0–12. All later payload bytes are 0. Payload byte p occupies nibbles 10+2p and 11+2p.
- R7: The command code is bits [2:0] of the command byte. Code 0 (null) is answered with sub-command 0x00 whatever sub-command was supplied. All other fields are copied unchanged.
- R8: Code 6 (revision) is answered with data byte 0 replaced by the REVISION parameter (default 0x21). The parameter holds two decimal digits, one per nibble.
- R9: After reset, a reply with command 0x00, sub-command 0x01, cell number 0, data count 0 and all data zero is sent at the first gap.
- R10: One pending slot holds requests. A request is taken if the slot is empty, or if the slot's content starts an insertion in the same clock. Otherwise the request is ignored and never produces a cell.
- R11: `reply_done` is a one-clock pulse in the clock in which nibble 105 of an inserted cell is on `dn_nib`. It never pulses for forwarded cells.
- R12: While `rst_n` is low, `dn_frm` and `reply_done` are 0 and `up_run` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_addr | input | 8 | Current switch address (reply VCI low byte) |
| req_valid | input | 1 | One-clock reply request strobe |
| req_cmd | input | 8 | Command byte to echo; bits [2:0] are the code |
| req_sub | input | 8 | Sub-command |
| req_cellno | input | 8 | Cell number |
| req_count | input | 8 | Data count |
| req_data | input | DATA_BYTES*8 | Data bytes, byte k at [8k+7:8k] |
| up_frm | input | 1 | Upstream frame marker |
| up_nib | input | 4 | Upstream nibble |
| up_run | output | 1 | Upstream read enable; 0 holds the source |
| dn_frm | output | 1 | Downstream frame marker |
| dn_nib | output | 4 | Downstream nibble |
| reply_done | output | 1 | Pulse on the last nibble of an inserted cell |

## Verification
The position tracker, the stall state and the nibble generator are internal, and an error in any of them shows up at the ports within one cell time. If the tracker starts an insertion in the wrong clock, a forwarded cell arrives split or shifted, so its 106 captured nibbles no longer match the pattern that was sent. If the stall is released too early or too late, nibbles of the held source are lost or duplicated, and the next forwarded cell fails its comparison. If the generator or the pending slot is wrong, the reply cell differs in a header, payload or done position, or cells arrive in the wrong order in the scoreboard.

// File: rtl/rci_pkg.sv
package rci_pkg;
  localparam int CELL_NIBS = 106;
  localparam int HDR_NIBS  = 10;
  localparam int PH_W      = $clog2(CELL_NIBS + 1);
  localparam int POS_W     = $clog2(CELL_NIBS);

  localparam logic [2:0] CODE_NULL = 3'd0;
  localparam logic [2:0] CODE_REV  = 3'd6;
  localparam logic [7:0] SUB_RESET = 8'h01;

  typedef struct packed {
    logic [7:0] cmd;
    logic [7:0] sub;
    logic [7:0] cellno;
    logic [7:0] count;
  } reply_hdr_t;
endpackage

// File: rtl/rci_rst_sync.sv
module rci_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rci_stream_track.sv
module rci_stream_track
  import rci_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic frm,
  output logic gap
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_NIBS - 1);

  logic             busy_q, busy_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             at_end;

  assign at_end = busy_q && (pos_q == LAST_POS);
  assign gap    = run && !frm && (!busy_q || at_end);

  always_comb begin
    busy_d = busy_q;
    pos_d  = pos_q;
    if (frm) begin
      busy_d = 1'b1;
      pos_d  = '0;
    end else if (busy_q) begin
      if (at_end) busy_d = 1'b0;
      else        pos_d  = pos_q + POS_W'(1);
    end
  end

  // Counters advance only while the upstream source is running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
    end else if (run) begin
      busy_q <= busy_d;
      pos_q  <= pos_d;
    end
  end
endmodule

// File: rtl/rci_reply_slot.sv
module rci_reply_slot
  import rci_pkg::*;
#(
  parameter int         DATA_BYTES = 13,
  parameter logic [7:0] REVISION   = 8'h21,
  localparam int        DW         = DATA_BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  reply_hdr_t    req_hdr,
  input  logic [DW-1:0] req_data,
  input  logic [7:0]    addr_in,
  input  logic          take,
  output logic          pend_valid,
  output reply_hdr_t    act_hdr,
  output logic [DW-1:0] act_data,
  output logic [7:0]    act_addr
);
  logic          pend_v_q, pend_v_d;
  reply_hdr_t    pend_hdr_q;
  logic [DW-1:0] pend_data_q;
  reply_hdr_t    shp_hdr;
  logic [DW-1:0] shp_data;
  logic          accept;

  assign accept     = req_valid && (!pend_v_q || take);
  assign pend_valid = pend_v_q;

  // Shape a request according to its command code.
  always_comb begin
    shp_hdr  = req_hdr;
    shp_data = req_data;
    if (req_hdr.cmd[2:0] == CODE_NULL) shp_hdr.sub   = 8'h00;
    if (req_hdr.cmd[2:0] == CODE_REV)  shp_data[7:0] = REVISION;
  end

  always_comb begin
    pend_v_d = pend_v_q;
    if (accept)    pend_v_d = 1'b1;
    else if (take) pend_v_d = 1'b0;
  end

  // Reset preloads the slot with a reset-notification reply.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q    <= 1'b1;
      pend_hdr_q  <= '{cmd: 8'h00, sub: SUB_RESET, cellno: 8'h00, count: 8'h00};
      pend_data_q <= '0;
    end else begin
      pend_v_q <= pend_v_d;
      if (accept) begin
        pend_hdr_q  <= shp_hdr;
        pend_data_q <= shp_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_hdr  <= '0;
      act_data <= '0;
      act_addr <= '0;
    end else if (take) begin
      act_hdr  <= pend_hdr_q;
      act_data <= pend_data_q;
      act_addr <= addr_in;
    end
  end
endmodule

// File: rtl/rci_serializer.sv
module rci_serializer
  import rci_pkg::*;
#(
  parameter int  DATA_BYTES = 13,
  localparam int DW         = DATA_BYTES * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  reply_hdr_t    act_hdr,
  input  logic [DW-1:0] act_data,
  input  logic [7:0]    act_addr,
  input  logic          up_frm,
  input  logic [3:0]    up_nib,
  output logic          up_run,
  output logic          dn_frm,
  output logic [3:0]    dn_nib,
  output logic          done
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CELL_NIBS);
  localparam logic [PH_W-1:0] PH_HDR  = PH_W'(HDR_NIBS);

  logic            ins_q, ins_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [PH_W-1:0] nib_idx, pl;
  logic [7:0]      byte_sel;
  logic [3:0]      gen_nib;
  logic            frm_d, done_d;
  logic [3:0]      nib_d;

  assign up_run = !ins_q;

  // Phase 0 is the frame marker; phase k (1..106) carries nibble k-1.
  always_comb begin
    ins_d = ins_q;
    ph_d  = ph_q;
    if (!ins_q) begin
      if (start) begin
        ins_d = 1'b1;
        ph_d  = '0;
      end
    end else if (ph_q == PH_LAST) begin
      ins_d = 1'b0;
    end else begin
      ph_d = ph_q + PH_W'(1);
    end
  end

  always_comb begin
    nib_idx  = ph_q - PH_W'(1);
    pl       = (nib_idx - PH_HDR) >> 1;
    byte_sel = 8'h00;
    case (pl)
      PH_W'(0): byte_sel = act_hdr.cmd;
      PH_W'(1): byte_sel = act_hdr.sub;
      PH_W'(2): byte_sel = act_hdr.cellno;
      PH_W'(3): byte_sel = act_hdr.count;
      default:  byte_sel = 8'h00;
    endcase
    for (int k = 0; k < DATA_BYTES; k++) begin
      if (pl == PH_W'(4 + k)) byte_sel = act_data[k*8 +: 8];
    end
    if (nib_idx < PH_HDR) begin
      if (nib_idx == PH_W'(5))      gen_nib = act_addr[7:4];
      else if (nib_idx == PH_W'(6)) gen_nib = act_addr[3:0];
      else                          gen_nib = 4'h0;
    end else begin
      gen_nib = nib_idx[0] ? byte_sel[3:0] : byte_sel[7:4];
    end
  end

  always_comb begin
    if (ins_q) begin
      frm_d  = (ph_q == '0);
      nib_d  = (ph_q == '0) ? 4'h0 : gen_nib;
      done_d = (ph_q == PH_LAST);
    end else begin
      frm_d  = up_frm;
      nib_d  = up_nib;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_q  <= 1'b0;
      ph_q   <= '0;
      dn_frm <= 1'b0;
      dn_nib <= 4'h0;
      done   <= 1'b0;
    end else begin
      ins_q  <= ins_d;
      ph_q   <= ph_d;
      dn_frm <= frm_d;
      dn_nib <= nib_d;
      done   <= done_d;
    end
  end
endmodule

// File: rtl/reply_cell_inserter.sv
module reply_cell_inserter
  import rci_pkg::*;
#(
  parameter int         DATA_BYTES = 13,
  parameter logic [7:0] REVISION   = 8'h21
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              sw_addr,
  input  logic                    req_valid,
  input  logic [7:0]              req_cmd,
  input  logic [7:0]              req_sub,
  input  logic [7:0]              req_cellno,
  input  logic [7:0]              req_count,
  input  logic [DATA_BYTES*8-1:0] req_data,
  input  logic                    up_frm,
  input  logic [3:0]              up_nib,
  output logic                    up_run,
  output logic                    dn_frm,
  output logic [3:0]              dn_nib,
  output logic                    reply_done
);
  localparam int DW = DATA_BYTES * 8;

  logic          rst_int_n;
  logic          gap, pend_valid, start;
  reply_hdr_t    req_hdr, act_hdr;
  logic [DW-1:0] act_data;
  logic [7:0]    act_addr;

  assign req_hdr = '{cmd: req_cmd, sub: req_sub, cellno: req_cellno, count: req_count};
  assign start   = gap && pend_valid;

  rci_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rci_stream_track u_track (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (up_run),
    .frm   (up_frm),
    .gap   (gap)
  );

  rci_reply_slot #(.DATA_BYTES(DATA_BYTES), .REVISION(REVISION)) u_slot (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_hdr    (req_hdr),
    .req_data   (req_data),
    .addr_in    (sw_addr),
    .take       (start),
    .pend_valid (pend_valid),
    .act_hdr    (act_hdr),
    .act_data   (act_data),
    .act_addr   (act_addr)
  );

  rci_serializer #(.DATA_BYTES(DATA_BYTES)) u_ser (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .act_hdr  (act_hdr),
    .act_data (act_data),
    .act_addr (act_addr),
    .up_frm   (up_frm),
    .up_nib   (up_nib),
    .up_run   (up_run),
    .dn_frm   (dn_frm),
    .dn_nib   (dn_nib),
    .done     (reply_done)
  );
endmodule

// File: rtl/rci_checker.sv
module rci_checker (
  input logic clk,
  input logic rst_n,
  input logic up_frm,
  input logic up_run,
  input logic dn_frm,
  input logic reply_done
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_outputs_R12: assert (!dn_frm && !reply_done && up_run);
    end
  end

  assert_frame_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_run) |=> dn_frm ##1 !dn_frm);

  assert_insert_at_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_run) |-> $past(!up_frm));

  assert_resume_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_run) |-> reply_done);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reply_done |=> !reply_done);

  assert_done_in_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reply_done |-> $past(!up_run));
endmodule

bind reply_cell_inserter rci_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .up_frm     (up_frm),
  .up_run     (up_run),
  .dn_frm     (dn_frm),
  .reply_done (reply_done)
);

// File: tb/reply_cell_inserter_bench.sv
module reply_cell_inserter_bench;
  localparam int SRC_LEN = 600;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [7:0]   sw_addr;
  logic         req_valid;
  logic [7:0]   req_cmd, req_sub, req_cellno, req_count;
  logic [103:0] req_data;
  logic         up_frm, up_run, dn_frm, reply_done;
  logic [3:0]   up_nib, dn_nib;

  always #4 clk = ~clk;

  reply_cell_inserter u_reply_cell_inserter (
    .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_sub(req_sub), .req_cellno(req_cellno),
    .req_count(req_count), .req_data(req_data), .up_frm(up_frm),
    .up_nib(up_nib), .up_run(up_run), .dn_frm(dn_frm), .dn_nib(dn_nib),
    .reply_done(reply_done)
  );

  typedef struct {
    logic [3:0] n [106];
    bit         ins;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0, cells_rx = 0, done_cnt = 0;
  bit   finished = 0, collecting = 0;

  logic       src_frm [SRC_LEN];
  logic [3:0] src_nib [SRC_LEN];
  int         idx = 0;

  assign up_frm = src_frm[idx];
  assign up_nib = src_nib[idx];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t mk_fwd(int a, int b, string tag);
    exp_t e;
    for (int i = 0; i < 106; i++) e.n[i] = 4'((i * a + b) & 15);
    e.ins = 0;
    e.tag = tag;
    return e;
  endfunction

  function automatic exp_t mk_reply(logic [7:0] cmd, logic [7:0] sub, logic [7:0] cno,
                                    logic [7:0] cnt, logic [103:0] data, logic [7:0] addr,
                                    string tag);
    exp_t e;
    logic [7:0] pb [48];
    for (int i = 0; i < 106; i++) e.n[i] = 4'h0;
    for (int p = 0; p < 48; p++) pb[p] = 8'h00;
    e.n[5] = addr[7:4];
    e.n[6] = addr[3:0];
    pb[0] = cmd; pb[1] = sub; pb[2] = cno; pb[3] = cnt;
    for (int k = 0; k < 13; k++) pb[4 + k] = data[k*8 +: 8];
    for (int p = 0; p < 48; p++) begin
      e.n[10 + 2*p] = pb[p][7:4];
      e.n[11 + 2*p] = pb[p][3:0];
    end
    e.ins = 1;
    e.tag = tag;
    return e;
  endfunction

  task automatic put_cell(int f, int a, int b);
    src_frm[f] = 1'b1;
    for (int i = 0; i < 106; i++) src_nib[f + 1 + i] = 4'((i * a + b) & 15);
  endtask

  task automatic send_req(logic [7:0] cmd, logic [7:0] sub, logic [7:0] cno,
                          logic [7:0] cnt, logic [103:0] data);
    @(posedge clk); #1;
    req_cmd = cmd; req_sub = sub; req_cellno = cno; req_count = cnt; req_data = data;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Upstream source model: advances only in clocks where up_run was high.
  initial begin
    bit run_s;
    while (rst_n !== 1'b1) @(posedge clk);
    forever begin
      @(negedge clk) run_s = up_run;
      @(posedge clk); #1;
      if (run_s && idx < SRC_LEN - 1) idx++;
    end
  end

  // Monitor / scoreboard
  initial begin
    logic [3:0] cur [106];
    int cnt = 0;
    bit done_last = 0, stray = 0;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        if (reply_done) done_cnt++;
        if (collecting) begin
          cur[cnt] = dn_nib;
          if (cnt == 105) done_last = reply_done;
          else if (reply_done) stray = 1;
          cnt++;
          if (cnt == 106) begin
            collecting = 0;
            cells_rx++;
            if (q.size() == 0) begin
              chk(0, "R10", "unexpected extra cell", cells_rx, 0);
            end else begin
              exp_t e;
              int bad;
              e = q.pop_front();
              bad = -1;
              for (int i = 105; i >= 0; i--) if (cur[i] !== e.n[i]) bad = i;
              if (bad < 0) chk(1, e.tag, "cell content", 0, 0);
              else chk(0, e.tag, $sformatf("cell nibble %0d", bad), cur[bad], e.n[bad]);
              chk((done_last && !stray) == e.ins, "R11", "done on last nibble",
                  int'(done_last && !stray), int'(e.ins));
            end
          end
        end else if (reply_done) begin
          stray = 1;
        end
        if (dn_frm) begin
          collecting = 1;
          cnt = 0;
          stray = 0;
          done_last = 0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R4: run did not complete, cells %0d expected 7", cells_rx);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    sw_addr = 8'h5A;
    req_valid = 1'b0;
    req_cmd = 0; req_sub = 0; req_cellno = 0; req_count = 0; req_data = '0;
    for (int i = 0; i < SRC_LEN; i++) begin
      src_frm[i] = 1'b0;
      src_nib[i] = 4'h0;
    end
    put_cell(10, 7, 3);    // cell A
    put_cell(116, 5, 1);   // cell B, back-to-back with A
    put_cell(300, 3, 9);   // cell C
    q.push_back(mk_reply(8'h00, 8'h01, 8'h00, 8'h00, '0, 8'h5A, "R9 reset reply"));
    q.push_back(mk_fwd(7, 3, "R1 R2 forwarded A"));
    q.push_back(mk_fwd(5, 1, "R3 back-to-back B"));
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dn_frm == 1'b0, "R12", "dn_frm in reset", dn_frm, 0);
    chk(reply_done == 1'b0, "R12", "reply_done in reset", reply_done, 0);
    chk(up_run == 1'b1, "R12", "up_run in reset", up_run, 1);
    @(posedge clk); #1 rst_n = 1'b1;

    while (idx < 50) @(negedge clk);
    q.push_back(mk_reply(8'h81, 8'h12, 8'h33, 8'h03, 104'h0D0C0B0A090807060504030201,
                         8'h5A, "R5 R6 read reply"));
    send_req(8'h81, 8'h12, 8'h33, 8'h03, 104'h0D0C0B0A090807060504030201);

    // Slot is occupied: this request must be dropped (R10).
    while (idx < 150) @(negedge clk);
    send_req(8'h82, 8'h99, 8'h77, 8'h02, 104'hFF);

    // Request during an insertion is held (R10) then sent as a revision reply (R8).
    while (!(idx > 222 && up_run == 1'b0)) @(negedge clk);
    q.push_back(mk_reply(8'h86, 8'h40, 8'h34, 8'h01, 104'hA0A0A0A0A0A0A0A0A0A0A0A021,
                         8'h5A, "R8 R10 revision reply"));
    send_req(8'h86, 8'h40, 8'h34, 8'h01, 104'hA0A0A0A0A0A0A0A0A0A0A0A055);

    while (idx < 350) @(negedge clk);
    q.push_back(mk_fwd(3, 9, "R4 resumed C"));
    sw_addr = 8'hC3;
    q.push_back(mk_reply(8'h80, 8'h00, 8'h05, 8'h00, 104'hAA, 8'hC3,
                         "R7 R5 null reply"));
    send_req(8'h80, 8'h77, 8'h05, 8'h00, 104'hAA);

    while (!(idx >= SRC_LEN - 1 && q.size() == 0 && !collecting)) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(cells_rx == 7, "R10", "total cells", cells_rx, 7);
    chk(done_cnt == 4, "R11", "done pulses", done_cnt, 4);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule